// File: doc/BRIEF.md
# Overflow-Toggle PWM Generator

This block produces one pulse-width-modulated output from a free-running modulo counter and one compare channel. The counter runs from zero up to a programmed limit and then wraps, and each wrap starts a new period. On every wrap the pin goes to its active level. When the counter reaches the compare value, the pin goes back to its inactive level. A single polarity input chooses whether the active pulse is high or low. A 3-bit divider select slows the counter relative to the clock.

The settings are plain level inputs, sampled continuously. While the generator is stopped it copies the limit and compare inputs straight into its working registers. While it runs, changes to those inputs take effect only at the next wrap, so a period already under way keeps its shape. After enable is raised the first period starts at counter value zero with the pin already active. Because there is no data stream, no valid/ready handshake is used, and every pin is a plain control or status pin.

Top module: `ovf_pwm`

## Requirements
- R1: The output period is (lim+1) x D clock cycles, where D is the divide ratio chosen by `div_sel`.
- R2: Each period, the pin is active for cmp x D cycles from the start of the period, then inactive until the period ends. With lim=255, cmp=128 and D=1, that is 128 active cycles out of 256.
- R3: With `pol_low`=0 the active level is 1 and the inactive level is 0. With `pol_low`=1 the active level is 0 and the inactive level is 1.
- R4: `div_sel` values 0 to 6 give D = 1, 2, 4, 8, 16, 32 and 64. Value 7 also gives D = 64.
- R5: A compare value of 0 holds the pin inactive for the whole period.
- R6: A compare value greater than lim never matches, so the pin is active for the whole period. A compare equal to lim leaves exactly one count inactive.
- R7: Raise `en` just before a clock edge. From that edge on the pin is active and the counter stands at 0 for D cycles.
- R8: One cycle after `en` is seen low, the pin sits at the inactive level (equal to `pol_low`) for as long as `en` stays low.
- R9: A new lim or cmp value applied while running first takes effect in the period that starts at the next wrap. The current period finishes with the old values.
- R10: While reset is held, the counter is 0 and the pin drives `pol_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| lim | input | CNT_W | Counter limit; the period is lim+1 counts |
| cmp | input | CNT_W | Compare value; the active width is cmp counts |
| pol_low | input | 1 | 1 makes the pulse active low |
| div_sel | input | 3 | Counter clock divider select |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench records the pin cycle by cycle and checks every position in each period. This catches a one-count error at either edge of the pulse, for example a design that matches on the old counter value instead of the next one. It drives compare values of 0, equal to lim, and above lim. A design that toggled blindly at the wrap, or matched without regard to the range, would show a wrong level in the second period. It changes lim and cmp in mid-period and checks that the old period still ends at its old length; a design that loaded the new values immediately would cut that period short. It also checks divider select 7 and the first count after enable, where a prescaler that was not cleared would lengthen or shorten count zero.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  localparam int SEL_W = 3;
  localparam int MAX_SHIFT = 6;

  function automatic int eff_shift(input logic [SEL_W-1:0] sel);
    int s;
    s = int'(sel);
    if (s > MAX_SHIFT) s = MAX_SHIFT;
    return s;
  endfunction
endpackage

// File: rtl/ovp_prescale.sv
module ovp_prescale
  import ovp_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << eff_shift(sel)) - 32'd1);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  // R4: with a divider above 1, two ticks never come back to back
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(tick) && $past(sel) != '0 && $stable(sel)) |-> !tick);
endmodule

// File: rtl/ovp_count.sv
module ovp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim_in,
  input  logic [CNT_W-1:0] cmp_in,
  output logic             wrap,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, lim_q, cmp_q;
  logic [CNT_W:0]   nxt;

  always_comb begin
    nxt  = {1'b0, cnt_q} + 1'b1;
    wrap = tick && (cnt_q == lim_q);
    hit  = tick && !wrap && (nxt == {1'b0, cmp_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      cmp_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      lim_q <= lim_in;
      cmp_q <= cmp_in;
    end else if (wrap) begin
      cnt_q <= '0;
      lim_q <= lim_in;
      cmp_q <= cmp_in;
    end else if (tick) begin
      cnt_q <= nxt[CNT_W-1:0];
    end
  end

  // R1: the count never passes the limit in force
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lim_q);
  // R9: a wrap picks up the settings present at that edge
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> (lim_q == $past(lim_in) && cmp_q == $past(cmp_in)));
  // R7: a fresh run starts at count zero
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0);
endmodule

// File: rtl/ovp_wave.sv
module ovp_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             hit,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             pol,
  output logic             pin
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              act_q <= 1'b0;
    else if (!run || wrap)   act_q <= (cmp_in != '0);
    else if (hit)            act_q <= 1'b0;
  end

  assign pin = pol ^ (run & act_q);

  // R5: a zero compare taken at a wrap leaves the pin inactive
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap && cmp_in == '0) |=> (!run || pin == pol));
endmodule

// File: rtl/ovf_pwm.sv
module ovf_pwm
  import ovp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] cmp,
  input  logic             pol_low,
  input  logic [SEL_W-1:0] div_sel,
  output logic             pwm_out
);
  logic run_q, tick, wrap, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  ovp_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(div_sel), .tick(tick)
  );

  ovp_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
    .lim_in(lim), .cmp_in(cmp), .wrap(wrap), .hit(hit)
  );

  ovp_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .run(run_q), .wrap(wrap), .hit(hit),
    .cmp_in(cmp), .pol(pol_low), .pin(pwm_out)
  );

  // R8: one cycle after enable drops, the pin is at the inactive level
  a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> pwm_out == pol_low);
endmodule

// File: tb/sim_ovf_pwm.sv
`timescale 1ns/1ps
module sim_ovf_pwm;
  logic clk = 0, rst_n = 0, en = 0, pol_low = 0;
  logic [15:0] lim = 0, cmp = 0;
  logic [2:0] div_sel = 0;
  logic pwm_out;
  int n_chk = 0, n_bad = 0;
  logic tr [0:1023];
  bit done = 0;

  always #4 clk = ~clk;

  ovf_pwm u0 (.clk(clk), .rst_n(rst_n), .en(en), .lim(lim), .cmp(cmp),
              .pol_low(pol_low), .div_sel(div_sel), .pwm_out(pwm_out));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic start(input int l, input int c, input logic p, input int s);
    @(negedge clk); en = 0;
    repeat (2) @(negedge clk);
    lim = 16'(l); cmp = 16'(c); pol_low = p; div_sel = 3'(s); en = 1;
  endtask

  task automatic record(input int n, input int chg, input int nl, input int nc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tr[i] = pwm_out;
      if (i == chg) begin lim = 16'(nl); cmp = 16'(nc); end
    end
  endtask

  task automatic pat(input string req, input int base, input int p, input int a);
    int bad_at = -1;
    logic got = 0, want = 0;
    for (int i = 0; i < p; i++) begin
      logic e;
      e = pol_low ^ (i < a);
      if (bad_at < 0 && tr[base+i] !== e) begin bad_at = base + i; got = tr[base+i]; want = e; end
    end
    n_chk++;
    if (bad_at >= 0) begin
      n_bad++;
      $display("FAIL %s at sample %0d actual=%0b expected=%0b (period %0d, active %0d)",
               req, bad_at, got, want, p, a);
    end
  endtask

  task automatic t_reset();
    chk("R10 reset level", pwm_out, 1'b0);
  endtask

  task automatic t_basic();
    start(255, 128, 0, 0); record(520, -1, 0, 0);
    chk("R7 active at start", tr[0], 1'b1);
    pat("R2 half duty period 0", 0, 256, 128);
    pat("R1 period 256 second", 256, 256, 128);
  endtask

  task automatic t_pol();
    start(9, 4, 1, 0); record(30, -1, 0, 0);
    chk("R3 active low start", tr[0], 1'b0);
    pat("R3 inverted pattern", 0, 10, 4);
    pat("R3 inverted pattern 2", 10, 10, 4);
    @(negedge clk); en = 0; @(negedge clk);
    chk("R8 idle at pol 1", pwm_out, 1'b1);
  endtask

  task automatic t_div();
    start(9, 3, 0, 2); record(90, -1, 0, 0);
    pat("R4 div4 period 0", 0, 40, 12);
    pat("R4 div4 period 1", 40, 40, 12);
    start(3, 1, 0, 6); record(520, -1, 0, 0);
    pat("R4 div64", 0, 256, 64);
    pat("R4 div64 period 1", 256, 256, 64);
    start(3, 1, 0, 7); record(520, -1, 0, 0);
    pat("R4 sel7 div64", 0, 256, 64);
  endtask

  task automatic t_edges();
    start(9, 0, 0, 0); record(40, -1, 0, 0);
    pat("R5 zero compare", 0, 10, 0);
    pat("R5 zero compare 2", 10, 10, 0);
    start(9, 20, 0, 0); record(40, -1, 0, 0);
    pat("R6 above limit", 0, 10, 10);
    pat("R6 above limit 2", 10, 10, 10);
    start(9, 9, 0, 1); record(60, -1, 0, 0);
    pat("R6 equal limit", 0, 20, 18);
    pat("R6 equal limit 2", 20, 20, 18);
  endtask

  task automatic t_reload();
    start(19, 5, 0, 0); record(50, 7, 9, 2);
    pat("R9 old period kept", 0, 20, 5);
    pat("R9 new period", 20, 10, 2);
    pat("R9 new period 2", 30, 10, 2);
  endtask

  task automatic t_off();
    start(9, 4, 0, 0); record(5, -1, 0, 0);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk("R8 inactive after disable", pwm_out, 1'b0);
    repeat (12) @(negedge clk);
    chk("R8 stays inactive", pwm_out, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic(); t_pol(); t_div(); t_edges(); t_reload(); t_off();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule